// File: doc/BRIEF.md
# Cascaded PWM Tick Generator

This block turns the bus clock into a set of clock-enable ticks for a bank of PWM counters. Two independent power-of-two prescalers, pair 0 and pair 1, each produce a base tick. Behind each prescaler sits a second, programmable scaler. It counts base ticks and produces a slower scaled tick. This gives four tick sources in all: base and scaled for each pair. Every output is a single bus-cycle enable pulse, not a derived clock, so all downstream logic stays in the bus clock domain.

Each PWM channel is tied by its channel number to one of the two pairs. A per-channel source bit then chooses either the base tick or the scaled tick of that pair. Software sets the block up through a small write-only register port with four registers. A write to a divider setting restarts the affected counters. The first tick after reconfiguration therefore comes a full new period later, and no short period occurs.

Top module: `pwm_tick_gen`

## Requirements
- R1: While reset is asserted, every tick output is low. Reset loads an exponent of 0 into both pairs, a scale value of 0 into both scalers and a source of 0 (base tick) into every channel. After reset is released, both base ticks and all channel ticks are high in every cycle.
- R2: Register address 0 holds the exponents. Bits [2:0] set the exponent n0 of pair 0 and bits [6:4] set the exponent n1 of pair 1. Base tick k of a pair pulses once every 2^n bus cycles, a ratio from 1 to 128.
- R3: Register address 1 holds scale value s0 and address 2 holds scale value s1. The scaled tick of a pair pulses once every 2*s base ticks of that pair. A scale value of 0 counts as 256, which gives 512 base ticks.
- R4: A scaled tick is only ever high in a cycle in which the base tick of the same pair is also high.
- R5: A write to address 0 restarts both prescalers and both scalers. Count cycle 0 as the first cycle after the write edge. Base ticks then fall at cycles 2^n, 2*2^n and so on, and scaled ticks fall at multiples of 2^n*2*s, with no pulse at cycle 0.
- R6: A write to address 1 or 2 restarts only the scaler of that pair, while its base tick keeps its phase. The first scaled tick after the write comes on the 2*s-th base tick, counting the base tick in cycle 0 as the first.
- R7: Register address 3 holds one source bit per channel, with bit i for channel i. A channel whose number mod 4 is 2 or 3 uses pair 1; every other channel uses pair 0. Source bit 0 selects the base tick and source bit 1 selects the scaled tick.
- R8: When the ratio is above 1, no base tick is high in two consecutive cycles, and no scaled tick is ever high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 exponents, 1 scale 0, 2 scale 1, 3 channel sources) |
| wr_data | input | 8 | Register write data |
| tick_pre | output | 2 | Base tick of pair 0 (bit 0) and pair 1 (bit 1) |
| tick_scl | output | 2 | Scaled tick of pair 0 (bit 0) and pair 1 (bit 1) |
| ch_tick | output | 6 | Selected tick for each PWM channel |

## Verification
The hardest case to reach is a restart of one scaler alone while its base tick runs on with a phase that the bench did not set. The stimulus first programs a base ratio of 1 through a full restart, which makes the base tick steady at every cycle. It then writes only the scale register, so that the expected scaled phase follows from the write edge alone, and it masks the other pair, whose phase is unknown at that point. The longest periods, a scale value of 0 (512 base ticks) on a ratio of 1 and a ratio of 128 with a small scale value, are each reached by a window sized to show two full scaled periods.

// File: rtl/tick_gen_pkg.sv
package tick_gen_pkg;

    typedef enum logic [1:0] {
        REG_DIVEXP = 2'd0,
        REG_SCALE0 = 2'd1,
        REG_SCALE1 = 2'd2,
        REG_CHSRC  = 2'd3
    } reg_sel_e;

    // Channel-to-pair routing is fixed by channel number (R7)
    function automatic logic ch_pair(input int unsigned ch);
        return ((ch % 4) >= 2);
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int unsigned EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic             tick_o
);
    localparam int unsigned CNT_W = (1 << EXP_W) - 1;
    localparam int unsigned RAT_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } st_t;

    st_t st_d, st_q;
    logic [RAT_W-1:0] ratio;
    logic [CNT_W-1:0] last;
    logic             match;

    always_comb begin
        ratio = RAT_W'(1) << exp_i;
        last  = CNT_W'(ratio - RAT_W'(1));
        match = (st_q.cnt == last);
        st_d  = st_q;
        st_d.tick = match && !restart_i;
        if (restart_i || match) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;

    // R5: the cycle after a restart never carries a tick
    a_r5_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !tick_o);

    // R8: with a ratio above 1, ticks are isolated pulses
    a_r8_pre_single: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && exp_i != '0 && !restart_i) |=> !tick_o);

endmodule

// File: rtl/tick_scaler.sv
module tick_scaler #(
    parameter int unsigned SCL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             base_tick_i,
    input  logic [SCL_W-1:0] scale_i,
    output logic             tick_o
);
    localparam int unsigned CNT_W = SCL_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] last;
    logic             hit;

    always_comb begin
        // 2*s - 1, with s = 0 wrapping to 2*256 - 1
        last = {scale_i - SCL_W'(1), 1'b1};
        hit  = base_tick_i && (st_q.cnt == last);
        st_d = st_q;
        if (restart_i || hit) begin
            st_d.cnt = '0;
        end else if (base_tick_i) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = hit;

    // R6: a restarted scaler cannot fire in the next cycle
    a_r6_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !tick_o);

    // R8: scaled ticks are never back to back
    a_r8_scl_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/tick_router.sv
module tick_router
    import tick_gen_pkg::*;
#(
    parameter int unsigned NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] src_i,
    input  logic [1:0]        pre_i,
    input  logic [1:0]        scl_i,
    output logic [NUM_CH-1:0] ch_tick_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic PAIR = ch_pair(c);
        always_comb begin
            ch_tick_o[c] = src_i[c] ? scl_i[PAIR] : pre_i[PAIR];
        end

        // R7: a channel tick always comes from its own pair
        a_r7_ch_source: assert property (@(posedge clk) disable iff (!rst_n)
            ch_tick_o[c] |-> (pre_i[PAIR] || scl_i[PAIR]));
    end

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
    import tick_gen_pkg::*;
#(
    parameter int unsigned NUM_CH = 6,
    parameter int unsigned EXP_W  = 3,
    parameter int unsigned SCL_W  = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [1:0]        tick_pre,
    output logic [1:0]        tick_scl,
    output logic [NUM_CH-1:0] ch_tick
);
    localparam int unsigned HI_LSB = DATA_W / 2;
    localparam int unsigned NPAIR  = 2;

    typedef struct packed {
        logic [NPAIR-1:0][EXP_W-1:0] expo;
        logic [NPAIR-1:0][SCL_W-1:0] scl;
        logic [NUM_CH-1:0]           src;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic             wr_div;
    logic [NPAIR-1:0] wr_scl;
    logic [NPAIR-1:0] scl_restart;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    always_comb begin
        cfg_d  = cfg_q;
        wr_div = wr_en && (wr_addr == REG_DIVEXP);
        wr_scl[0] = wr_en && (wr_addr == REG_SCALE0);
        wr_scl[1] = wr_en && (wr_addr == REG_SCALE1);
        if (wr_div) begin
            cfg_d.expo[0] = wr_data[EXP_W-1:0];
            cfg_d.expo[1] = wr_data[HI_LSB +: EXP_W];
        end
        if (wr_scl[0]) cfg_d.scl[0] = wr_data[SCL_W-1:0];
        if (wr_scl[1]) cfg_d.scl[1] = wr_data[SCL_W-1:0];
        if (wr_en && (wr_addr == REG_CHSRC)) begin
            cfg_d.src = wr_data[NUM_CH-1:0];
        end
        scl_restart = wr_scl | {NPAIR{wr_div}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        tick_prescaler #(.EXP_W(EXP_W)) u_pre (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart_i (wr_div),
            .exp_i     (cfg_q.expo[g]),
            .tick_o    (tick_pre[g])
        );

        tick_scaler #(.SCL_W(SCL_W)) u_scl (
            .clk         (clk),
            .rst_n       (rst_n),
            .restart_i   (scl_restart[g]),
            .base_tick_i (tick_pre[g]),
            .scale_i     (cfg_q.scl[g]),
            .tick_o      (tick_scl[g])
        );

        // R4: scaled tick only coincides with a base tick of its pair
        a_r4_scl_subset: assert property (@(posedge clk) disable iff (!rst_n)
            tick_scl[g] |-> tick_pre[g]);
    end

    tick_router #(.NUM_CH(NUM_CH)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (cfg_q.src),
        .pre_i     (tick_pre),
        .scl_i     (tick_scl),
        .ch_tick_o (ch_tick)
    );

endmodule

// File: tb/pwm_tick_gen_tb_top.sv
module pwm_tick_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic [1:0]        tick_pre;
    logic [1:0]        tick_scl;
    logic [NUM_CH-1:0] ch_tick;

    int n_vec = 0;
    int n_bad = 0;

    typedef struct {
        logic [9:0] vec;
        logic [9:0] mask;
        string      t_pre;
        string      t_scl;
        string      t_ch;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_tick_gen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .tick_pre (tick_pre),
        .tick_scl (tick_scl),
        .ch_tick  (ch_tick)
    );

    wire [9:0] got = {ch_tick, tick_scl, tick_pre};

    task automatic check_item(input exp_t it);
        logic [9:0] diff;
        diff = (got ^ it.vec) & it.mask;
        n_vec++;
        if (diff != '0 || (|(tick_scl & ~tick_pre))) begin
            n_bad++;
            if (|diff[1:0])
                $display("FAIL %s base ticks got %b exp %b", it.t_pre, got[1:0], it.vec[1:0]);
            if (|diff[3:2])
                $display("FAIL %s scaled ticks got %b exp %b", it.t_scl, got[3:2], it.vec[3:2]);
            if (|diff[9:4])
                $display("FAIL %s channel ticks got %b exp %b", it.t_ch, got[9:4], it.vec[9:4]);
            if (|(tick_scl & ~tick_pre))
                $display("FAIL R4 scaled %b without base %b exp subset", tick_scl, tick_pre);
        end
    endtask

    // Monitor: one expected item per cycle, sampled at the falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) check_item(exp_q.pop_front());
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
    endtask

    // Driver: expected ticks after a full restart (R2, R3, R5, R7, R8)
    task automatic push_restart(input int pa, input int pb, input int s0, input int s1,
                                input logic [5:0] src, input int n);
        int ra, rb, rs0, rs1;
        ra  = 1 << pa;
        rb  = 1 << pb;
        rs0 = ra * 2 * ((s0 == 0) ? 256 : s0);
        rs1 = rb * 2 * ((s1 == 0) ? 256 : s1);
        for (int k = 0; k < n; k++) begin
            exp_t it;
            logic p0, p1, q0, q1;
            p0 = (k > 0) && (k % ra == 0);
            p1 = (k > 0) && (k % rb == 0);
            q0 = (k > 0) && (k % rs0 == 0);
            q1 = (k > 0) && (k % rs1 == 0);
            it.vec[0] = p0;
            it.vec[1] = p1;
            it.vec[2] = q0;
            it.vec[3] = q1;
            for (int i = 0; i < NUM_CH; i++) begin
                logic hi;
                hi = ((i % 4) >= 2);
                it.vec[4+i] = src[i] ? (hi ? q1 : q0) : (hi ? p1 : p0);
            end
            it.mask  = '1;
            it.t_pre = "R2 R5 R8";
            it.t_scl = "R3 R5";
            it.t_ch  = "R7";
            exp_q.push_back(it);
        end
    endtask

    task automatic run_cfg(input int pa, input int pb, input int s0, input int s1,
                           input logic [5:0] src, input int n);
        wr(2'd3, {2'b00, src});
        wr(2'd1, 8'(s0));
        wr(2'd2, 8'(s1));
        wr(2'd0, {1'b0, 3'(pb), 1'b0, 3'(pa)});
        push_restart(pa, pb, s0, s1, src, n);
        drain();
    endtask

    initial begin
        // R1: outputs held low in reset
        repeat (3) begin
            @(negedge clk);
            n_vec++;
            if (got !== 10'd0) begin
                n_bad++;
                $display("FAIL R1 reset outputs got %b exp %b", got, 10'd0);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R1: defaults give base and channel ticks every cycle
        for (int k = 0; k < 5; k++) begin
            exp_t it;
            it.vec   = 10'b1111110011;
            it.mask  = 10'b1111110011;
            it.t_pre = "R1";
            it.t_scl = "R1";
            it.t_ch  = "R1";
            exp_q.push_back(it);
        end
        drain();

        run_cfg(0, 2, 1, 3, 6'b000000, 100);
        run_cfg(3, 7, 2, 1, 6'b111111, 600);
        run_cfg(7, 0, 1, 0, 6'b010101, 1100);
        run_cfg(0, 1, 0, 5, 6'b101010, 1100);

        // R6: scale-only write on pair 0 while its base ticks every cycle
        wr(2'd1, 8'd3);
        for (int k = 0; k < 30; k++) begin
            exp_t it;
            logic q0;
            q0 = ((k + 1) % 6 == 0);
            it.vec = '0;
            it.vec[0] = 1'b1;
            it.vec[2] = q0;
            it.vec[4] = 1'b1;
            it.vec[5] = q0;
            it.vec[8] = 1'b1;
            it.vec[9] = q0;
            it.mask  = 10'b1100110101;
            it.t_pre = "R6";
            it.t_scl = "R6";
            it.t_ch  = "R6 R7";
            exp_q.push_back(it);
        end
        drain();

        @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired got running exp finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule